// File: doc/BRIEF.md
# Atomic Reservation Monitor for a Shared Word Memory

This block lets several requesters perform atomic read-modify-write sequences on one small word-addressed memory without locking it. Each requester first issues a reserving load, which returns the current word and records a reservation on that address for that requester. It later issues a conditional store to the same address. The conditional store commits only if the reservation survived. It reports 1 on success and 0 on failure, so software loops until it sees 1.

A reservation is lost when another requester successfully writes the reserved word, either with a plain store or with a winning conditional store. A plain store, such as releasing a lock word to 0, always commits. One request is served per cycle. When several ports ask in the same cycle, the lowest-numbered one is granted and the others hold their request until their ready goes high. The response arrives one cycle after the grant, on the port that was granted.

Top module: `atomic_rsv_monitor`

## Requirements
- R1: After reset no response is valid, every reservation is clear and every memory word reads 0.
- R2: Each cycle, ready is high only for the lowest-numbered port with valid high. A port holding valid without ready is not served that cycle.
- R3: A reserving load (opcode 2'b00) returns, one cycle after its grant and on the issuing port's response valid only, the word stored before that cycle. It does not change memory.
- R4: A conditional store (opcode 2'b01) whose requester holds an intact reservation on the same address writes its data and responds with 1 in bit 0 and zeros above.
- R5: A conditional store with no reservation, or a reservation on a different address, responds with 0 and leaves memory unchanged.
- R6: A successful write by one port cancels the reservations of all other ports on that address. Writes to other addresses leave those reservations intact.
- R7: A conditional store clears the issuing port's own reservation whether it succeeds or fails. An immediate second conditional store therefore fails.
- R8: A new reserving load replaces that port's previous reservation. Only the latest address can succeed.
- R9: A plain store (opcode 2'b10) always writes and responds with 0. It does not cancel the storing port's own reservation.
- R10: Opcode 2'b11 is granted and responds with 0. It changes neither memory nor any reservation.
- R11: When several reserving ports issue conditional stores to the same word in the same cycle, the lowest port succeeds. The others fail without writing, and the word holds the winner's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS | Request valid per port |
| reqOp | input | 2*NUM_PORTS | Opcode per port (00 reserve-load, 01 conditional store, 10 plain store, 11 none) |
| reqAddr | input | ADDR_W*NUM_PORTS | Word address per port |
| reqData | input | DATA_W*NUM_PORTS | Write data per port |
| reqReady | output | NUM_PORTS | Grant for this cycle, one-hot or zero |
| rspValid | output | NUM_PORTS | Response valid, one cycle after grant |
| rspData | output | DATA_W | Loaded word, or the success flag in bit 0 |

## Verification
The main sweep runs through every combination of reserving port, reserved address and an intruding store address from another port. Only an intruding store to the same address may turn the conditional store into a failure, so a wrong address compare or a missing cancellation shows up as a mismatch. Short directed sequences tell apart the cancellation and replacement cases: the own-store case, a repeated conditional store, a re-reservation to a new address and the unused opcode. A same-cycle race of three conditional stores separates the priority order from the single-winner rule.

// File: rtl/atomic_rsv_pkg.sv
package atomic_rsv_pkg;
  typedef enum logic [1:0] {
    OP_LL   = 2'b00,
    OP_SC   = 2'b01,
    OP_ST   = 2'b10,
    OP_NONE = 2'b11
  } rsvOp_e;

  typedef struct packed {
    logic memWe;
    logic rspLoad;
    logic rspIsFlag;
    logic scOk;
  } ctlStrobe_t;
endpackage

// File: rtl/atomic_rsv_ctrl.sv
module atomic_rsv_ctrl
  import atomic_rsv_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 3,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          reqValid,
  input  logic [2*NUM_PORTS-1:0]        reqOp,
  input  logic [ADDR_W*NUM_PORTS-1:0]   reqAddr,
  output logic [NUM_PORTS-1:0]          grantVec,
  output logic [IDX_W-1:0]              grantIdx,
  output ctlStrobe_t                    strobe
);

  logic              anyGrant;
  rsvOp_e            gOp;
  logic [ADDR_W-1:0] gAddr;
  logic [NUM_PORTS-1:0] rsvValid;
  logic [ADDR_W-1:0] rsvAddr [NUM_PORTS];
  logic              scOk;

  // fixed priority: lowest index wins, so scan downward and let the last hit stand
  always_comb begin
    grantVec = '0;
    grantIdx = '0;
    anyGrant = 1'b0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (reqValid[i]) begin
        grantVec    = '0;
        grantVec[i] = 1'b1;
        grantIdx    = IDX_W'(i);
        anyGrant    = 1'b1;
      end
    end
  end

  assign gOp   = rsvOp_e'(reqOp[grantIdx*2 +: 2]);
  assign gAddr = reqAddr[grantIdx*ADDR_W +: ADDR_W];
  assign scOk  = anyGrant && (gOp == OP_SC) && rsvValid[grantIdx] &&
                 (rsvAddr[grantIdx] == gAddr);

  always_comb begin
    strobe.memWe     = anyGrant && ((gOp == OP_ST) || scOk);
    strobe.rspLoad   = anyGrant;
    strobe.rspIsFlag = (gOp != OP_LL);
    strobe.scOk      = scOk;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rsv
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsvValid[p] <= 1'b0;
        rsvAddr[p]  <= '0;
      end else if (grantVec[p]) begin
        if (gOp == OP_LL) begin
          rsvValid[p] <= 1'b1;
          rsvAddr[p]  <= gAddr;
        end else if (gOp == OP_SC) begin
          rsvValid[p] <= 1'b0;
        end
      end else if (strobe.memWe && (rsvAddr[p] == gAddr)) begin
        rsvValid[p] <= 1'b0;
      end
    end

    AST_LL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (grantVec[p] && gOp == OP_LL) |=> (rsvValid[p] && rsvAddr[p] == $past(gAddr))); // R8
    AST_SC_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      (grantVec[p] && gOp == OP_SC) |=> !rsvValid[p]); // R7
    AST_FOREIGN_WRITE_BREAKS: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.memWe && !grantVec[p] && rsvAddr[p] == gAddr) |=> !rsvValid[p]); // R6
    AST_NONE_KEEPS_RSV: assert property (@(posedge clk) disable iff (!rst_n)
      (grantVec[p] && gOp == OP_NONE) |=> $stable(rsvValid[p])); // R10
  end

endmodule

// File: rtl/atomic_rsv_datapath.sv
module atomic_rsv_datapath
  import atomic_rsv_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ctlStrobe_t                    strobe,
  input  logic [NUM_PORTS-1:0]          grantVec,
  input  logic [IDX_W-1:0]              grantIdx,
  input  logic [ADDR_W*NUM_PORTS-1:0]   reqAddr,
  input  logic [DATA_W*NUM_PORTS-1:0]   reqData,
  output logic [NUM_PORTS-1:0]          rspValid,
  output logic [DATA_W-1:0]             rspData
);

  logic [DEPTH-1:0][DATA_W-1:0] mem;
  logic [ADDR_W-1:0]            gAddr;
  logic [DATA_W-1:0]            gData;

  assign gAddr = reqAddr[grantIdx*ADDR_W +: ADDR_W];
  assign gData = reqData[grantIdx*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (strobe.memWe) begin
      mem[gAddr] <= gData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= '0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.rspLoad ? grantVec : '0;
      if (!strobe.rspLoad)       rspData <= '0;
      else if (strobe.rspIsFlag) rspData <= DATA_W'(strobe.scOk);
      else                       rspData <= mem[gAddr];
    end
  end

  AST_MEM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.memWe |=> $stable(mem)); // R5
  AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.rspLoad |=> ($countones(rspValid) == 1)); // R3

endmodule

// File: rtl/atomic_rsv_monitor.sv
module atomic_rsv_monitor
  import atomic_rsv_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          reqValid,
  input  logic [2*NUM_PORTS-1:0]        reqOp,
  input  logic [ADDR_W*NUM_PORTS-1:0]   reqAddr,
  input  logic [DATA_W*NUM_PORTS-1:0]   reqData,
  output logic [NUM_PORTS-1:0]          reqReady,
  output logic [NUM_PORTS-1:0]          rspValid,
  output logic [DATA_W-1:0]             rspData
);

  ctlStrobe_t        strobe;
  logic [IDX_W-1:0]  grantIdx;

  atomic_rsv_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .grantVec(reqReady), .grantIdx(grantIdx), .strobe(strobe)
  );

  atomic_rsv_datapath #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .grantVec(reqReady),
    .grantIdx(grantIdx), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData)
  );

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqReady)); // R2
  AST_PORT0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid[0] |-> reqReady[0]); // R2
  AST_RSP_IS_PAST_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (reqReady != '0) |=> (rspValid == $past(reqReady))); // R3

endmodule

// File: tb/atomic_rsv_monitor_tb.sv
`timescale 1ns/1ps
module atomic_rsv_monitor_tb_top;
  localparam int NP = 3;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   reqValid = '0;
  logic [2*NP-1:0] reqOp = '0;
  logic [AW*NP-1:0] reqAddr = '0;
  logic [DW*NP-1:0] reqData = '0;
  logic [NP-1:0]   reqReady;
  logic [NP-1:0]   rspValid;
  logic [DW-1:0]   rspData;

  int nChecks = 0;
  int nErrors = 0;
  logic [DW-1:0] model [DEPTH];

  always #4 clk = ~clk;

  atomic_rsv_monitor #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqReady(reqReady),
    .rspValid(rspValid), .rspData(rspData)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one request alone; returns the response word
  task automatic doOne(input int p, input logic [1:0] op, input int a, input int d,
                       output logic [DW-1:0] r);
    @(negedge clk);
    reqValid = '0;
    reqValid[p] = 1'b1;
    reqOp[p*2 +: 2] = op;
    reqAddr[p*AW +: AW] = AW'(a);
    reqData[p*DW +: DW] = DW'(d);
    #1;
    check(reqReady == NP'(1 << p), "R2 ready", reqReady, 1 << p);
    @(posedge clk);
    #2;
    reqValid = '0;
    check(rspValid == NP'(1 << p), "R3 rspValid", rspValid, 1 << p);
    r = rspData;
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [DW-1:0] r;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(rspValid == '0, "R1 rspValid in reset", rspValid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(reqReady == '0, "R1 ready idle", reqReady, 0);
    check(rspValid == '0, "R1 rspValid idle", rspValid, 0);

    // R1 memory cleared, R5 store-conditional with no reservation
    for (int a = 0; a < DEPTH; a++) begin
      doOne(a % NP, 2'b11, a, 0, r);
      doOne((a + 1) % NP, 2'b01, a, 8'h55, r);
      check(r == 0, "R5 no reservation", r, 0);
    end
    for (int a = 0; a < DEPTH; a++) begin
      doOne(2, 2'b00, a, 0, r);
      check(r == 0, "R1 word zero after reset", r, 0);
    end

    // sweep: reserving port p, address a, foreign store to w
    for (int p = 0; p < NP; p++) begin
      for (int a = 0; a < DEPTH; a++) begin
        for (int w = 0; w < DEPTH; w++) begin
          int q;
          int dSt;
          int dSc;
          logic expOk;
          q = (p + 1) % NP;
          dSt = (p * 64 + a * 8 + w) & 8'hff;
          dSc = (~dSt) & 8'hff;
          doOne(p, 2'b00, a, 0, r);
          check(r == model[a], "R3 load value", r, model[a]);
          doOne(q, 2'b10, w, dSt, r);
          check(r == 0, "R9 store response", r, 0);
          model[w] = DW'(dSt);
          expOk = (w != a);
          doOne(p, 2'b01, a, dSc, r);
          check(r == DW'(expOk), expOk ? "R4 sc success" : "R6 sc after foreign write", r, expOk);
          if (expOk) model[a] = DW'(dSc);
          doOne(q, 2'b00, a, 0, r);
          check(r == model[a], expOk ? "R4 sc wrote" : "R5 failed sc no write", r, model[a]);
        end
      end
    end

    // R7 second sc fails
    doOne(1, 2'b00, 4, 0, r);
    doOne(1, 2'b01, 4, 8'h3c, r);
    check(r == 1, "R7 first sc", r, 1);
    doOne(1, 2'b01, 4, 8'h99, r);
    check(r == 0, "R7 second sc fails", r, 0);
    doOne(0, 2'b00, 4, 0, r);
    check(r == 8'h3c, "R7 memory kept", r, 8'h3c);

    // R7 failed sc also clears: reservation broken then rearmed? no, failed sc clears
    doOne(2, 2'b00, 6, 0, r);
    doOne(2, 2'b01, 5, 8'h11, r);
    check(r == 0, "R5 wrong address", r, 0);
    doOne(2, 2'b01, 6, 8'h12, r);
    check(r == 0, "R7 cleared by failed sc", r, 0);

    // R8 replacement
    doOne(0, 2'b00, 1, 0, r);
    doOne(0, 2'b00, 2, 0, r);
    doOne(0, 2'b01, 1, 8'h21, r);
    check(r == 0, "R8 old address fails", r, 0);
    doOne(0, 2'b00, 1, 0, r);
    doOne(0, 2'b00, 2, 0, r);
    doOne(0, 2'b01, 2, 8'h22, r);
    check(r == 1, "R8 new address wins", r, 1);

    // R9 own plain store keeps own reservation
    doOne(1, 2'b00, 7, 0, r);
    doOne(1, 2'b10, 7, 8'h70, r);
    check(r == 0, "R9 store response", r, 0);
    doOne(1, 2'b01, 7, 8'h71, r);
    check(r == 1, "R9 own store keeps reservation", r, 1);
    doOne(2, 2'b00, 7, 0, r);
    check(r == 8'h71, "R9 value", r, 8'h71);

    // R6 sc win by another port cancels
    doOne(0, 2'b00, 3, 0, r);
    doOne(1, 2'b00, 3, 0, r);
    doOne(1, 2'b01, 3, 8'h31, r);
    check(r == 1, "R6 winner", r, 1);
    doOne(0, 2'b01, 3, 8'h32, r);
    check(r == 0, "R6 loser after sc write", r, 0);

    // R10 unused opcode
    doOne(2, 2'b00, 0, 0, r);
    doOne(2, 2'b11, 0, 8'hee, r);
    check(r == 0, "R10 response", r, 0);
    doOne(0, 2'b00, 0, 0, r);
    check(r == model[0], "R10 memory unchanged", r, model[0]);
    doOne(2, 2'b01, 0, 8'h0f, r);
    check(r == 1, "R10 reservation kept", r, 1);

    // R11 same-cycle race
    for (int p = 0; p < NP; p++) doOne(p, 2'b00, 5, 0, r);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      reqOp[p*2 +: 2] = 2'b01;
      reqAddr[p*AW +: AW] = AW'(5);
      reqData[p*DW +: DW] = DW'(8'ha0 + p);
    end
    reqValid = '1;
    for (int k = 0; k < NP; k++) begin
      #1;
      check(reqReady == NP'(1 << k), "R11 grant order", reqReady, 1 << k);
      @(posedge clk);
      #2;
      check(rspValid == NP'(1 << k), "R11 response port", rspValid, 1 << k);
      check(rspData == DW'(k == 0), "R11 single winner", rspData, k == 0);
      reqValid[k] = 1'b0;
      @(negedge clk);
    end
    doOne(1, 2'b00, 5, 0, r);
    check(r == 8'ha0, "R11 winner data", r, 8'ha0);

    finish();
  end
endmodule